// File: doc/BRIEF.md
# Banked Scratchpad and Special-Register Window

This block holds the 256-byte internal register RAM of an 8-bit controller core together with the 128-byte special-function register window, which shares its upper address range. Each access arrives with an addressing mode, and the mode alone decides the target. A direct access to an address of 80h or above lands in the special registers. Every other mode that reaches those addresses lands in RAM. Working-register numbers are remapped into one of four banks of eight bytes. The bank is chosen by two bits of the status register.

Single-bit accesses reach the bit-addressable RAM bytes 20h–2Fh and the special registers whose addresses have their low three bits clear. A bit write is a read-modify-write of the containing byte and completes in one cycle. Push and pop go through a stack pointer held in the special-register window. A push increments the pointer and then writes. A pop reads and then decrements. Only three special registers are implemented: the status register at D0h, the accumulator at E0h and the stack pointer at 81h. All other special-register addresses read as zero and ignore writes.

An access is presented for one cycle with `req_i` high. The byte read, taken before any write in that same cycle, appears on `rdata_o` from the next clock edge.

Top module: `scratchpad_sfr_core`

## Requirements
- R1: On reset, the stack pointer is 07h, the status register, accumulator, all RAM bytes, `rdata_o` and `rbit_o` are zero.
- R2: Mode 0 (direct) with an address below 80h, and mode 1 (indirect) with any address, read or write the RAM byte at that address. The byte value before the write appears on `rdata_o` the cycle after the request.
- R3: Mode 0 with an address of 80h or above reaches the special registers: D0h status, E0h accumulator, 81h stack pointer. Any other address there reads 00h, and a write to it changes nothing, including the RAM byte at the same address.
- R4: Mode 2 (register) addresses RAM byte status[4:3]×8 + addr_i[2:0].
- R5: Mode 3 (register-indirect) reads the pointer from register addr_i[0] of the current bank and accesses the RAM byte at that pointer, over the full range 00h–FFh.
- R6: Mode 4 (bit) with a bit address below 80h selects RAM byte 20h + addr_i[6:3], bit addr_i[2:0]. `rbit_o` returns that bit and `rdata_o` returns the whole byte.
- R7: Mode 4 with a bit address of 80h or above selects the special register at address addr_i with bits 2:0 cleared, bit addr_i[2:0]. An unimplemented register reads bit 0.
- R8: A bit write replaces only the selected bit with `wbit_i`, within one cycle. All other bits of the byte are unchanged.
- R9: Mode 5 (push) writes `wdata_i` to RAM at SP+1 and sets SP to SP+1, wrapping from FFh to 00h.
- R10: Mode 6 (pop) returns RAM[SP] on `rdata_o` and sets SP to SP−1, wrapping from 00h to FFh.
- R11: With `req_i` low, or with mode 7, nothing changes: no register, RAM byte, `rdata_o` or `rbit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access valid this cycle |
| mode_i | input | 3 | Addressing mode (0 direct … 6 pop, 7 none) |
| we_i | input | 1 | Write enable (ignored for push/pop) |
| addr_i | input | 8 | Byte address, register number or bit address |
| wdata_i | input | 8 | Byte write data / push data |
| wbit_i | input | 1 | Bit write value |
| rdata_o | output | 8 | Byte read, before write, registered |
| rbit_o | output | 1 | Selected bit in bit mode, otherwise 0 |
| psw_o | output | 8 | Status register |
| acc_o | output | 8 | Accumulator |
| sp_o | output | 8 | Stack pointer |

## Verification
The assertions assume that `mode_i` and `addr_i` are known whenever `req_i` is high. They also assume that nothing outside the block changes the status or stack registers, so that any step in `psw_o` or `sp_o` can be traced to the previous cycle's request. The stimulus drives every access for exactly one cycle and parks `req_i` low between accesses. It deliberately presents write-enabled stimulus while idle and in mode 7, to show that such input does no harm. The sweeps cover every RAM address in both byte modes, every low bit address, every status and accumulator bit, all four banks, and stack wrap in both directions.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 8;
  localparam int unsigned DEPTH     = 1 << AW;
  localparam int unsigned REG_BITS  = 3;
  localparam int unsigned BANK_BITS = 2;
  localparam int unsigned BPOS_W    = $clog2(DW);

  typedef enum logic [2:0] {
    AM_DIRECT  = 3'd0,
    AM_INDIR   = 3'd1,
    AM_REG     = 3'd2,
    AM_REG_IND = 3'd3,
    AM_BIT     = 3'd4,
    AM_PUSH    = 3'd5,
    AM_POP     = 3'd6,
    AM_NONE    = 3'd7
  } acc_mode_e;
endpackage

// File: rtl/spd_ram.sv
module spd_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))      mem_q[i] <= wdata_i;
    end
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = mem_q[rb_addr_i];
endmodule

// File: rtl/spd_sfr.sv
module spd_sfr #(
  parameter int unsigned  DW       = 8,
  parameter int unsigned  AW       = 8,
  parameter logic [DW-1:0] SP_RST  = 8'h07,
  parameter logic [AW-1:0] PSW_ADR = 8'hD0,
  parameter logic [AW-1:0] ACC_ADR = 8'hE0,
  parameter logic [AW-1:0] SP_ADR  = 8'h81
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sp_inc_i,
  input  logic          sp_dec_i,
  output logic [DW-1:0] psw_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] sp_o
);
  logic [DW-1:0] psw_q, acc_q, sp_q;

  always_comb begin
    unique case (rd_addr_i)
      PSW_ADR: rd_data_o = psw_q;
      ACC_ADR: rd_data_o = acc_q;
      SP_ADR:  rd_data_o = sp_q;
      default: rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
      acc_q <= '0;
    end else if (we_i) begin
      if (rd_addr_i == PSW_ADR) psw_q <= wdata_i;
      if (rd_addr_i == ACC_ADR) acc_q <= wdata_i;
    end
  end

  // write port shares the read address: an SFR is touched only by the access that selects it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            sp_q <= SP_RST;
    else if (we_i && rd_addr_i == SP_ADR)   sp_q <= wdata_i;
    else if (sp_inc_i)                      sp_q <= sp_q + DW'(1);
    else if (sp_dec_i)                      sp_q <= sp_q - DW'(1);
  end

  assign psw_o = psw_q;
  assign acc_o = acc_q;
  assign sp_o  = sp_q;
endmodule

// File: rtl/spd_resolver.sv
module spd_resolver
  import spd_pkg::*;
#(
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  acc_mode_e              mode_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [BANK_BITS-1:0]   bank_i,
  input  logic [AW-1:0]          sp_i,
  input  logic [DW-1:0]          ptr_i,
  output logic                   valid_o,
  output logic [AW-1:0]          ea_o,
  output logic                   sfr_o,
  output logic                   bit_op_o,
  output logic [BPOS_W-1:0]      bpos_o,
  output logic                   push_o,
  output logic                   pop_o
);
  localparam int unsigned BYTE_SEL_W = AW - 1 - BPOS_W;

  always_comb begin
    valid_o  = 1'b1;
    ea_o     = addr_i;
    sfr_o    = 1'b0;
    bit_op_o = 1'b0;
    bpos_o   = addr_i[BPOS_W-1:0];
    push_o   = 1'b0;
    pop_o    = 1'b0;
    unique case (mode_i)
      AM_DIRECT:  sfr_o = addr_i[AW-1];
      AM_INDIR:   ea_o  = addr_i;
      AM_REG:     ea_o  = AW'({bank_i, addr_i[REG_BITS-1:0]});
      AM_REG_IND: ea_o  = AW'(ptr_i);
      AM_BIT: begin
        bit_op_o = 1'b1;
        if (addr_i[AW-1]) begin
          sfr_o = 1'b1;
          ea_o  = {addr_i[AW-1:BPOS_W], {BPOS_W{1'b0}}};
        end else begin
          ea_o  = BIT_BASE + AW'(addr_i[AW-2 -: BYTE_SEL_W]);
        end
      end
      AM_PUSH: begin
        push_o = 1'b1;
        ea_o   = sp_i + AW'(1);
      end
      AM_POP: begin
        pop_o = 1'b1;
        ea_o  = sp_i;
      end
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/scratchpad_sfr_core.sv
module scratchpad_sfr_core
  import spd_pkg::*;
#(
  parameter logic [7:0] SP_RST   = 8'h07,
  parameter logic [7:0] PSW_ADR  = 8'hD0,
  parameter logic [7:0] ACC_ADR  = 8'hE0,
  parameter logic [7:0] SP_ADR   = 8'h81,
  parameter logic [7:0] BIT_BASE = 8'h20,
  parameter int unsigned BANK_LSB = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [2:0] mode_i,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wbit_i,
  output logic [7:0] rdata_o,
  output logic       rbit_o,
  output logic [7:0] psw_o,
  output logic [7:0] acc_o,
  output logic [7:0] sp_o
);
  logic [BANK_BITS-1:0] bank;
  logic [AW-1:0]        ptr_idx, ea;
  logic [DW-1:0]        ptr, ram_rd, sfr_rd, old_byte, bit_byte, wr_byte;
  logic                 valid, sfr_sel, bit_op, push_op, pop_op, act, wr_en;
  logic [BPOS_W-1:0]    bpos;
  logic [DW-1:0]        rdata_q;
  logic                 rbit_q;

  assign bank    = psw_o[BANK_LSB +: BANK_BITS];
  assign ptr_idx = AW'({bank, {(REG_BITS-1){1'b0}}, addr_i[0]});

  spd_resolver #(.BIT_BASE(BIT_BASE)) u_res (
    .mode_i  (acc_mode_e'(mode_i)),
    .addr_i  (addr_i),
    .bank_i  (bank),
    .sp_i    (sp_o),
    .ptr_i   (ptr),
    .valid_o (valid),
    .ea_o    (ea),
    .sfr_o   (sfr_sel),
    .bit_op_o(bit_op),
    .bpos_o  (bpos),
    .push_o  (push_op),
    .pop_o   (pop_op)
  );

  assign act      = req_i && valid;
  assign old_byte = sfr_sel ? sfr_rd : ram_rd;
  assign bit_byte = (old_byte & ~(DW'(1) << bpos)) | (DW'(wbit_i) << bpos);
  assign wr_byte  = push_op ? wdata_i : (bit_op ? bit_byte : wdata_i);
  assign wr_en    = act && (push_op || (we_i && !pop_op));

  spd_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_addr_i(ea),
    .ra_data_o(ram_rd),
    .rb_addr_i(ptr_idx),
    .rb_data_o(ptr),
    .we_i     (wr_en && !sfr_sel),
    .waddr_i  (ea),
    .wdata_i  (wr_byte)
  );

  spd_sfr #(
    .DW(DW), .AW(AW), .SP_RST(SP_RST),
    .PSW_ADR(PSW_ADR), .ACC_ADR(ACC_ADR), .SP_ADR(SP_ADR)
  ) u_sfr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_addr_i(ea),
    .rd_data_o(sfr_rd),
    .we_i     (wr_en && sfr_sel),
    .wdata_i  (wr_byte),
    .sp_inc_i (act && push_op),
    .sp_dec_i (act && pop_op),
    .psw_o    (psw_o),
    .acc_o    (acc_o),
    .sp_o     (sp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rbit_q  <= 1'b0;
    end else if (act) begin
      rdata_q <= old_byte;
      rbit_q  <= bit_op & old_byte[bpos];
    end
  end

  assign rdata_o = rdata_q;
  assign rbit_o  = rbit_q;
endmodule

// File: rtl/spd_checker.sv
module spd_checker
  import spd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic [2:0] mode_i,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic       wbit_i,
  input logic [7:0] rdata_o,
  input logic       rbit_o,
  input logic [7:0] psw_o,
  input logic [7:0] acc_o,
  input logic [7:0] sp_o
);
  logic idle;
  assign idle = !req_i || mode_i == 3'(AM_NONE);

  a_r3_psw_direct_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i == 3'(AM_DIRECT) && !we_i && addr_i == 8'hD0 |=> rdata_o == $past(psw_o));

  a_r8_psw_bit_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i == 3'(AM_BIT) && we_i && addr_i[7:3] == 5'b11010 |=>
      psw_o[$past(addr_i[2:0])] == $past(wbit_i) &&
      ((psw_o ^ $past(psw_o)) & ~(8'b1 << $past(addr_i[2:0]))) == 8'h00);

  a_r9_push_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i == 3'(AM_PUSH) |=> sp_o == $past(sp_o) + 8'd1);

  a_r10_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i == 3'(AM_POP) |=> sp_o == $past(sp_o) - 8'd1);

  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> $stable(psw_o) && $stable(acc_o) && $stable(sp_o) && $stable(rdata_o) && $stable(rbit_o));

  a_r6_rbit_only_in_bit_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && mode_i != 3'(AM_BIT) && mode_i != 3'(AM_NONE) |=> !rbit_o);
endmodule

bind scratchpad_sfr_core spd_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .mode_i (mode_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wbit_i (wbit_i),
  .rdata_o(rdata_o),
  .rbit_o (rbit_o),
  .psw_o  (psw_o),
  .acc_o  (acc_o),
  .sp_o   (sp_o)
);

// File: tb/tb_scratchpad_sfr_core.sv
`timescale 1ns/1ps
module tb_scratchpad_sfr_core;
  import spd_pkg::*;

  localparam real CLK_NS = 4.0;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       req_i = 1'b0;
  logic [2:0] mode_i = 3'd0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic       wbit_i = 1'b0;
  logic [7:0] rdata_o, psw_o, acc_o, sp_o;
  logic       rbit_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  logic [7:0] m_mem [256];
  logic [7:0] m_psw = 8'h00, m_acc = 8'h00, m_sp = 8'h07;
  logic [7:0] m_rd  = 8'h00;
  logic       m_rb  = 1'b0;

  always #(CLK_NS/2) clk_i = ~clk_i;

  scratchpad_sfr_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .wbit_i(wbit_i), .rdata_o(rdata_o),
    .rbit_o(rbit_o), .psw_o(psw_o), .acc_o(acc_o), .sp_o(sp_o)
  );

  function automatic logic [7:0] sfr_rd(input logic [7:0] a);
    case (a)
      8'hD0:   return m_psw;
      8'hE0:   return m_acc;
      8'h81:   return m_sp;
      default: return 8'h00;
    endcase
  endfunction

  task automatic sfr_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'hD0: m_psw = d;
      8'hE0: m_acc = d;
      8'h81: m_sp  = d;
      default: ;
    endcase
  endtask

  task automatic check_all(input string tag);
    n_vec++;
    if (rdata_o !== m_rd || rbit_o !== m_rb || psw_o !== m_psw || acc_o !== m_acc || sp_o !== m_sp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h rbit=%b psw=%h acc=%h sp=%h expected rdata=%h rbit=%b psw=%h acc=%h sp=%h",
               tag, rdata_o, rbit_o, psw_o, acc_o, sp_o, m_rd, m_rb, m_psw, m_acc, m_sp);
    end
  endtask

  task automatic op(input logic [2:0] m, input logic [7:0] a, input logic w,
                    input logic [7:0] d, input logic b, input string tag);
    logic [7:0] ea, old, nb;
    logic sfr, bop, wr;
    ea = a; sfr = 1'b0; bop = 1'b0; wr = w;
    case (m)
      3'd0: sfr = a[7];
      3'd1: ;
      3'd2: ea = {3'b000, m_psw[4:3], a[2:0]};
      3'd3: ea = m_mem[{3'b000, m_psw[4:3], 2'b00, a[0]}];
      3'd4: begin
        bop = 1'b1;
        if (a[7]) begin sfr = 1'b1; ea = {a[7:3], 3'b000}; end
        else ea = 8'h20 + {4'h0, a[6:3]};
      end
      3'd5: begin ea = m_sp + 8'd1; wr = 1'b1; end
      3'd6: begin ea = m_sp; wr = 1'b0; end
      default: ;
    endcase
    if (m != 3'd7) begin
      old  = sfr ? sfr_rd(ea) : m_mem[ea];
      m_rd = old;
      m_rb = bop ? old[a[2:0]] : 1'b0;
      nb   = d;
      if (bop) begin nb = old; nb[a[2:0]] = b; end
      if (wr) begin
        if (sfr) sfr_wr(ea, nb);
        else     m_mem[ea] = nb;
      end
      if (m == 3'd5) m_sp = m_sp + 8'd1;
      if (m == 3'd6) m_sp = m_sp - 8'd1;
    end
    @(negedge clk_i);
    req_i = 1'b1; mode_i = m; addr_i = a; we_i = w; wdata_i = d; wbit_i = b;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R11: watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_all("R1 reset state");
    rst_ni = 1'b1;

    // R2: indirect fill and readback over all 256 bytes, direct readback of lower half
    for (int a = 0; a < 256; a++) op(AM_INDIR, 8'(a), 1'b1, 8'(a * 37 + 11), 1'b0, "R2 indirect write");
    for (int a = 0; a < 256; a++) op(AM_INDIR, 8'(a), 1'b0, 8'h00, 1'b0, "R2 indirect read");
    for (int a = 0; a < 128; a++) op(AM_DIRECT, 8'(a), 1'b0, 8'h00, 1'b0, "R2 direct read");
    for (int a = 0; a < 128; a++) op(AM_DIRECT, 8'(a), 1'b1, 8'(a ^ 8'hC3), 1'b0, "R2 direct write");
    for (int a = 0; a < 128; a++) op(AM_INDIR, 8'(a), 1'b0, 8'h00, 1'b0, "R2 direct write readback");

    // R3: SFR window by direct addressing
    for (int a = 128; a < 256; a++) op(AM_DIRECT, 8'(a), 1'b0, 8'h00, 1'b0, "R3 sfr read");
    op(AM_DIRECT, 8'hD0, 1'b1, 8'hA5, 1'b0, "R3 psw write");
    op(AM_DIRECT, 8'hE0, 1'b1, 8'h3C, 1'b0, "R3 acc write");
    op(AM_DIRECT, 8'h81, 1'b1, 8'h30, 1'b0, "R3 sp write");
    op(AM_DIRECT, 8'h90, 1'b1, 8'hFF, 1'b0, "R3 unmodeled sfr write");
    op(AM_DIRECT, 8'h90, 1'b0, 8'h00, 1'b0, "R3 unmodeled sfr reads zero");
    op(AM_INDIR, 8'h90, 1'b0, 8'h00, 1'b0, "R3 ram behind sfr untouched");
    op(AM_INDIR, 8'hD0, 1'b0, 8'h00, 1'b0, "R3 ram behind psw untouched");

    // R4: register banks
    for (int bk = 0; bk < 4; bk++) begin
      op(AM_DIRECT, 8'hD0, 1'b1, 8'(bk << 3), 1'b0, "R4 bank select");
      for (int r = 0; r < 8; r++) op(AM_REG, 8'(r), 1'b1, 8'(bk * 16 + r + 8'h80), 1'b0, "R4 reg write");
    end
    for (int a = 0; a < 32; a++) op(AM_DIRECT, 8'(a), 1'b0, 8'h00, 1'b0, "R4 bank byte readback");
    for (int bk = 0; bk < 4; bk++) begin
      op(AM_DIRECT, 8'hD0, 1'b1, 8'(8'hE7 & ~8'h18 | 8'(bk << 3)), 1'b0, "R4 bank select other bits set");
      for (int r = 0; r < 8; r++) op(AM_REG, {5'b11111, 3'(r)}, 1'b0, 8'h00, 1'b0, "R4 reg read high bits ignored");
    end

    // R5: register-indirect through R0/R1 of each bank
    for (int bk = 0; bk < 4; bk++) begin
      op(AM_DIRECT, 8'hD0, 1'b1, 8'(bk << 3), 1'b0, "R5 bank select");
      op(AM_REG, 8'd0, 1'b1, 8'(8'hC0 + bk * 4), 1'b0, "R5 set R0");
      op(AM_REG, 8'd1, 1'b1, 8'(8'h40 + bk), 1'b0, "R5 set R1");
      op(AM_REG_IND, 8'd0, 1'b1, 8'(8'h5A + bk), 1'b0, "R5 write via R0");
      op(AM_REG_IND, 8'd1, 1'b1, 8'(8'hA0 + bk), 1'b0, "R5 write via R1");
      op(AM_INDIR, 8'(8'hC0 + bk * 4), 1'b0, 8'h00, 1'b0, "R5 upper byte readback");
      op(AM_INDIR, 8'(8'h40 + bk), 1'b0, 8'h00, 1'b0, "R5 lower byte readback");
      op(AM_REG_IND, 8'd0, 1'b0, 8'h00, 1'b0, "R5 read via R0");
    end

    // R6/R8: bit space in RAM
    for (int ba = 0; ba < 128; ba++) op(AM_BIT, 8'(ba), 1'b0, 8'h00, 1'b0, "R6 bit read");
    for (int ba = 0; ba < 128; ba++) begin
      logic cur;
      cur = m_mem[8'h20 + ba / 8][ba % 8];
      op(AM_BIT, 8'(ba), 1'b1, 8'hFF, ~cur, "R8 bit toggle");
    end
    for (int a = 8'h1F; a <= 8'h30; a++) op(AM_DIRECT, 8'(a), 1'b0, 8'h00, 1'b0, "R8 byte after bit writes");

    // R7: bit space in SFRs
    op(AM_DIRECT, 8'hD0, 1'b1, 8'h00, 1'b0, "R7 psw clear");
    for (int i = 0; i < 8; i++) op(AM_BIT, 8'(8'hD0 + i), 1'b1, 8'h00, 1'(i % 2), "R7 psw bit write");
    for (int i = 0; i < 8; i++) op(AM_BIT, 8'(8'hE0 + i), 1'b1, 8'h00, 1'(i < 4), "R7 acc bit write");
    for (int i = 0; i < 8; i++) op(AM_BIT, 8'(8'hE0 + i), 1'b0, 8'h00, 1'b0, "R7 acc bit read");
    for (int i = 0; i < 8; i++) op(AM_BIT, 8'(8'h88 + i), 1'b1, 8'h00, 1'b1, "R7 unmodeled sfr bit");
    op(AM_INDIR, 8'h88, 1'b0, 8'h00, 1'b0, "R7 ram behind bit sfr untouched");

    // R9/R10: stack with wrap
    op(AM_DIRECT, 8'h81, 1'b1, 8'hFD, 1'b0, "R9 sp set");
    for (int i = 0; i < 4; i++) op(AM_PUSH, 8'h00, 1'b0, 8'(8'h11 * (i + 1)), 1'b0, "R9 push wrap");
    op(AM_INDIR, 8'h00, 1'b0, 8'h00, 1'b0, "R9 pushed byte at 00");
    op(AM_INDIR, 8'hFF, 1'b0, 8'h00, 1'b0, "R9 pushed byte at FF");
    for (int i = 0; i < 4; i++) op(AM_POP, 8'h00, 1'b1, 8'hEE, 1'b0, "R10 pop wrap");
    op(AM_INDIR, 8'hFE, 1'b0, 8'h00, 1'b0, "R10 pop leaves ram");

    // R11: idle and reserved mode
    op(AM_NONE, 8'hD0, 1'b1, 8'hFF, 1'b1, "R11 reserved mode");
    op(AM_NONE, 8'h20, 1'b1, 8'hFF, 1'b1, "R11 reserved mode on ram");
    op(AM_INDIR, 8'h20, 1'b0, 8'h00, 1'b0, "R11 ram after reserved mode");
    @(negedge clk_i);
    req_i = 1'b0; mode_i = AM_DIRECT; we_i = 1'b1; addr_i = 8'hE0; wdata_i = 8'hFF;
    @(negedge clk_i);
    we_i = 1'b0;
    check_all("R11 idle with write enable");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule